// File: doc/BRIEF.md
# SIMD Floating-Point Signaling Unordered-or-Not-Equal Compare

This block takes one 32-bit instruction word and two 128-bit source vectors. It compares the two vectors lane by lane as IEEE 754 floating-point values. A format bit in the instruction selects the lane layout:

- four binary32 lanes, or
- two binary64 lanes.

A lane whose operands are unordered (at least one NaN) or not equal gets all ones in the result. Every other lane gets all zeros. The result is therefore an integer mask of the same lane width, ready for later select or blend operations.

The compare is signaling, so any NaN operand raises the invalid-operation flag. A flush-to-zero control input makes subnormal operands act as signed zeros. Each such flush is reported on its own flag and never as inexact. Flags from all lanes are ORed into one output per flag type.

The result and flags are registered and appear one clock after an accepted request, together with an output strobe. A request whose encoding does not match produces a reserved-instruction pulse instead, and the held result does not change.

Top module: `vfcmp_top`

## Requirements
- R1: A request is accepted only when instruction bits [31:26] = 6'b011110, bits [25:22] = 4'b1010 and bits [5:0] = 6'b011100. Bits [20:6] (three 5-bit register indices) do not affect acceptance.
- R2: When bit [21] is 0, the vectors are four binary32 lanes, lane i at bits [32i+31:32i].
- R3: When bit [21] is 1, the vectors are two binary64 lanes, lane i at bits [64i+63:64i]. Bit patterns that would be NaN in a binary32 view have no effect.
- R4: Each result lane is all ones when its operands are unordered or not equal, and all zeros when they are equal. No lane is ever partially set.
- R5: A NaN in either operand of a lane, quiet or signaling, sets out_inv and forces that lane to all ones.
- R6: +0 and -0 compare equal, giving an all-zeros lane and no flag.
- R7: With in_ftz = 1, a subnormal operand compares as a zero of its own sign, and out_ftzd is set. With in_ftz = 0, subnormals compare by value and out_ftzd stays 0.
- R8: out_inv and out_ftzd are the OR over all lanes of the selected format.
- R9: An accepted request updates out_mask, out_inv and out_ftzd on the next rising clock edge, with out_valid high for exactly that one cycle.
- R10: A request that fails the R1 match raises out_rsvd for one cycle, keeps out_valid low, and leaves out_mask, out_inv and out_ftzd unchanged.
- R11: During synchronous reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_instr | input | 32 | Instruction word |
| in_vs | input | 128 | First source vector |
| in_vt | input | 128 | Second source vector |
| in_ftz | input | 1 | Flush subnormal operands to zero |
| out_valid | output | 1 | Result strobe, one cycle after an accepted request |
| out_mask | output | 128 | Per-lane all-ones / all-zeros result |
| out_inv | output | 1 | Invalid-operation flag, OR over lanes |
| out_ftzd | output | 1 | Subnormal-flushed flag, OR over lanes |
| out_rsvd | output | 1 | Reserved-instruction pulse for a non-matching encoding |

## Verification
Almost all state in this block is the single output register stage, so an internal fault appears at the ports in the very next cycle. A wrong lane split or format select shows up there as a mask with a lane at the wrong boundary, or as a NaN seen where only the other format contains one. A classification error in a lane shows up as a flipped lane in the mask or a wrong flag in that same cycle. A decode fault is visible immediately, either as out_valid and out_rsvd swapped or as a held mask that changes when it should not.

// File: rtl/vfcmp_pkg.sv
package vfcmp_pkg;

    localparam int VEC_W    = 128;
    localparam int SGL_EXP  = 8;
    localparam int SGL_MAN  = 23;
    localparam int DBL_EXP  = 11;
    localparam int DBL_MAN  = 52;
    localparam int SGL_W    = 1 + SGL_EXP + SGL_MAN;
    localparam int DBL_W    = 1 + DBL_EXP + DBL_MAN;
    localparam int N_SGL    = VEC_W / SGL_W;
    localparam int N_DBL    = VEC_W / DBL_W;

    localparam logic [5:0] ENC_MAJOR = 6'b011110;
    localparam logic [3:0] ENC_OP    = 4'b1010;
    localparam logic [5:0] ENC_MINOR = 6'b011100;

    typedef enum logic {
        FMT_SGL = 1'b0,
        FMT_DBL = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [5:0] major;
        logic [3:0] op;
        logic       fmt;
        logic [4:0] rt;
        logic [4:0] rs;
        logic [4:0] rd;
        logic [5:0] minor;
    } instr_t;

    typedef struct packed {
        logic hit;
        logic inv;
        logic ftzd;
    } lane_res_t;

    typedef struct packed {
        logic [VEC_W-1:0] mask;
        logic             inv;
        logic             ftzd;
    } vec_res_t;

    function automatic logic enc_match(instr_t i);
        return (i.major == ENC_MAJOR) && (i.op == ENC_OP) && (i.minor == ENC_MINOR);
    endfunction

endpackage

// File: rtl/vfcmp_decode.sv
module vfcmp_decode
    import vfcmp_pkg::*;
(
    input  logic [31:0] instr,
    output logic        match,
    output fmt_e        fmt
);
    instr_t fields;
    logic   unused_regs;

    always_comb begin
        fields      = instr_t'(instr);
        match       = enc_match(fields);
        fmt         = fmt_e'(fields.fmt);
        unused_regs = ^{fields.rt, fields.rs, fields.rd};
    end
endmodule

// File: rtl/vfcmp_lane.sv
module vfcmp_lane
    import vfcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    input  logic                 ftz,
    output lane_res_t            res
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] ea, eb;
    logic [MAN_W-1:0] ma, mb;
    logic nan_a, nan_b, sub_a, sub_b, zero_a, zero_b, same;

    always_comb begin
        ea     = a[W-2:MAN_W];
        eb     = b[W-2:MAN_W];
        ma     = a[MAN_W-1:0];
        mb     = b[MAN_W-1:0];
        nan_a  = (&ea) && (|ma);
        nan_b  = (&eb) && (|mb);
        sub_a  = (~|ea) && (|ma);
        sub_b  = (~|eb) && (|mb);
        zero_a = (~|ea) && ((~|ma) || ftz);
        zero_b = (~|eb) && ((~|mb) || ftz);
        same   = (a == b) || (zero_a && zero_b);
        res.hit  = nan_a || nan_b || !same;
        res.inv  = nan_a || nan_b;
        res.ftzd = ftz && (sub_a || sub_b);
    end
endmodule

// File: rtl/vfcmp_vec.sv
module vfcmp_vec
    import vfcmp_pkg::*;
(
    input  logic [VEC_W-1:0] vs,
    input  logic [VEC_W-1:0] vt,
    input  logic             ftz,
    input  fmt_e             fmt,
    output vec_res_t         res
);
    lane_res_t        s_res [N_SGL];
    lane_res_t        d_res [N_DBL];
    logic [VEC_W-1:0] s_mask, d_mask;
    logic [N_SGL-1:0] s_inv, s_ftzd;
    logic [N_DBL-1:0] d_inv, d_ftzd;

    for (genvar g = 0; g < N_SGL; g++) begin : g_sgl
        vfcmp_lane #(.EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) u_lane (
            .a  (vs[SGL_W*g +: SGL_W]),
            .b  (vt[SGL_W*g +: SGL_W]),
            .ftz(ftz),
            .res(s_res[g])
        );
        assign s_mask[SGL_W*g +: SGL_W] = {SGL_W{s_res[g].hit}};
        assign s_inv[g]  = s_res[g].inv;
        assign s_ftzd[g] = s_res[g].ftzd;
    end

    for (genvar g = 0; g < N_DBL; g++) begin : g_dbl
        vfcmp_lane #(.EXP_W(DBL_EXP), .MAN_W(DBL_MAN)) u_lane (
            .a  (vs[DBL_W*g +: DBL_W]),
            .b  (vt[DBL_W*g +: DBL_W]),
            .ftz(ftz),
            .res(d_res[g])
        );
        assign d_mask[DBL_W*g +: DBL_W] = {DBL_W{d_res[g].hit}};
        assign d_inv[g]  = d_res[g].inv;
        assign d_ftzd[g] = d_res[g].ftzd;
    end

    always_comb begin
        if (fmt == FMT_DBL) begin
            res.mask = d_mask;
            res.inv  = |d_inv;
            res.ftzd = |d_ftzd;
        end else begin
            res.mask = s_mask;
            res.inv  = |s_inv;
            res.ftzd = |s_ftzd;
        end
    end
endmodule

// File: rtl/vfcmp_top.sv
module vfcmp_top
    import vfcmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [31:0]        in_instr,
    input  logic [VEC_W-1:0]   in_vs,
    input  logic [VEC_W-1:0]   in_vt,
    input  logic               in_ftz,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_mask,
    output logic               out_inv,
    output logic               out_ftzd,
    output logic               out_rsvd
);
    logic     match;
    fmt_e     fmt;
    fmt_e     r_fmt;
    vec_res_t nxt;
    logic     accept;

    vfcmp_decode u_dec (
        .instr(in_instr),
        .match(match),
        .fmt  (fmt)
    );

    vfcmp_vec u_vec (
        .vs (in_vs),
        .vt (in_vt),
        .ftz(in_ftz),
        .fmt(fmt),
        .res(nxt)
    );

    assign accept = in_valid && match;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rsvd  <= 1'b0;
            out_mask  <= '0;
            out_inv   <= 1'b0;
            out_ftzd  <= 1'b0;
            r_fmt     <= FMT_SGL;
        end else begin
            out_valid <= accept;
            out_rsvd  <= in_valid && !match;
            if (accept) begin
                out_mask <= nxt.mask;
                out_inv  <= nxt.inv;
                out_ftzd <= nxt.ftzd;
                r_fmt    <= fmt;
            end
        end
    end

    for (genvar g = 0; g < N_SGL; g++) begin : g_chk_sgl
        assert_lane_uniform_R4: assert property (@(posedge clk) disable iff (rst)
            (out_valid && r_fmt == FMT_SGL) |->
            (out_mask[SGL_W*g +: SGL_W] == '0 || &out_mask[SGL_W*g +: SGL_W]));
    end

    for (genvar g = 0; g < N_DBL; g++) begin : g_chk_dbl
        assert_dlane_uniform_R4: assert property (@(posedge clk) disable iff (rst)
            (out_valid && r_fmt == FMT_DBL) |->
            (out_mask[DBL_W*g +: DBL_W] == '0 || &out_mask[DBL_W*g +: DBL_W]));
    end

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    assert_rsvd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !match) |=> (out_rsvd && !out_valid));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(out_mask) && $stable(out_inv) && $stable(out_ftzd)));

    assert_ftz_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_ftz) |=> !out_ftzd);

    assert_inv_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_inv) |-> (out_mask != '0));
endmodule

// File: tb/vfcmp_top_test.sv
module vfcmp_top_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  in_instr = '0;
    logic [127:0] in_vs = '0;
    logic [127:0] in_vt = '0;
    logic         in_ftz = 1'b0;
    logic         out_valid, out_inv, out_ftzd, out_rsvd;
    logic [127:0] out_mask;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] S1 = 32'h3F800000, S2 = 32'h40000000, SINF = 32'h7F800000;
    localparam logic [31:0] SQN = 32'h7FC00000, SSN = 32'h7F800001;
    localparam logic [31:0] SPZ = 32'h00000000, SNZ = 32'h80000000;
    localparam logic [31:0] SSUB = 32'h00000001, SNSUB = 32'h80000001;
    localparam logic [31:0] ONES = 32'hFFFFFFFF, ZER = 32'h0;
    localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
    localparam logic [63:0] DQN = 64'h7FF8000000000000, DNZ = 64'h8000000000000000;

    vfcmp_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_vs(in_vs), .in_vt(in_vt), .in_ftz(in_ftz),
        .out_valid(out_valid), .out_mask(out_mask), .out_inv(out_inv),
        .out_ftzd(out_ftzd), .out_rsvd(out_rsvd)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic [31:0] mk(logic [5:0] maj, logic [3:0] op, logic df,
                                       logic [14:0] regs, logic [5:0] mn);
        return {maj, op, df, regs, mn};
    endfunction

    task automatic chk_vec(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] ins, logic [127:0] a, logic [127:0] b, logic ftz);
        @(negedge clk);
        in_valid = 1'b1; in_instr = ins; in_vs = a; in_vt = b; in_ftz = ftz;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(string req, logic [127:0] m, logic inv, logic fz);
        chk_bit({req, " valid"}, out_valid, 1'b1);
        chk_bit({req, " rsvd"}, out_rsvd, 1'b0);
        chk_vec({req, " mask"}, out_mask, m);
        chk_bit({req, " inv"}, out_inv, inv);
        chk_bit({req, " ftzd"}, out_ftzd, fz);
    endtask

    task automatic t_reset;
        chk_bit("R11 valid", out_valid, 1'b0);
        chk_bit("R11 rsvd", out_rsvd, 1'b0);
        chk_vec("R11 mask", out_mask, '0);
        chk_bit("R11 inv", out_inv, 1'b0);
        chk_bit("R11 ftzd", out_ftzd, 1'b0);
    endtask

    task automatic t_sgl_basic;
        issue(mk(6'b011110, 4'b1010, 1'b0, 15'h1234, 6'b011100),
              {S1, S1, S2, SINF}, {S1, S2, S2, SINF}, 1'b0);
        expect_res("R2 R4 R9 sgl ordered", {ZER, ONES, ZER, ZER}, 1'b0, 1'b0);
        @(negedge clk);
        chk_bit("R9 single-cycle strobe", out_valid, 1'b0);
    endtask

    task automatic t_sgl_nan;
        issue(mk(6'b011110, 4'b1010, 1'b0, 15'h7FFF, 6'b011100),
              {S1, SPZ, SSN, SQN}, {S1, SNZ, S1, SQN}, 1'b0);
        expect_res("R5 R6 sgl nan and signed zero", {ZER, ZER, ONES, ONES}, 1'b1, 1'b0);
    endtask

    task automatic t_sgl_one_lane_nan;
        issue(mk(6'b011110, 4'b1010, 1'b0, 15'h0000, 6'b011100),
              {SSN, S2, S1, S2}, {S2, S2, S1, S2}, 1'b0);
        expect_res("R8 flag from top lane", {ONES, ZER, ZER, ZER}, 1'b1, 1'b0);
    endtask

    task automatic t_ftz;
        issue(mk(6'b011110, 4'b1010, 1'b0, 15'h0000, 6'b011100),
              {S1, S2, SNSUB, SSUB}, {S1, S2, SNZ, SPZ}, 1'b1);
        expect_res("R7 flush on", {ZER, ZER, ZER, ZER}, 1'b0, 1'b1);
        issue(mk(6'b011110, 4'b1010, 1'b0, 15'h0000, 6'b011100),
              {S1, S2, SNSUB, SSUB}, {S1, S2, SNZ, SPZ}, 1'b0);
        expect_res("R7 flush off", {ZER, ZER, ONES, ONES}, 1'b0, 1'b0);
        issue(mk(6'b011110, 4'b1010, 1'b0, 15'h0000, 6'b011100),
              {S1, S2, SSUB, SSUB}, {S1, S2, SSUB, SSUB}, 1'b0);
        expect_res("R7 equal subnormals by value", '0, 1'b0, 1'b0);
    endtask

    task automatic t_dbl;
        issue(mk(6'b011110, 4'b1010, 1'b1, 15'h0421, 6'b011100),
              {DNZ, 64'h000000007FC00000}, {64'h0, 64'h000000007FC00000}, 1'b0);
        expect_res("R3 R6 dbl no nan in 64-bit view", '0, 1'b0, 1'b0);
        issue(mk(6'b011110, 4'b1010, 1'b1, 15'h0421, 6'b011100),
              {DQN, D1}, {D1, D2}, 1'b0);
        expect_res("R3 R5 dbl lanes", {128{1'b1}}, 1'b1, 1'b0);
        issue(mk(6'b011110, 4'b1010, 1'b1, 15'h0421, 6'b011100),
              {D2, D1}, {D2, D2}, 1'b0);
        expect_res("R3 R4 dbl lane split", {64'h0, {64{1'b1}}}, 1'b0, 1'b0);
    endtask

    task automatic t_rsvd(string req, logic [31:0] ins);
        logic [127:0] held;
        held = out_mask;
        issue(ins, {S1, S1, S1, SQN}, {S2, S2, S2, S2}, 1'b1);
        chk_bit({req, " rsvd"}, out_rsvd, 1'b1);
        chk_bit({req, " valid"}, out_valid, 1'b0);
        chk_vec({req, " mask held"}, out_mask, held);
        chk_bit({req, " inv held"}, out_inv, 1'b0);
        chk_bit({req, " ftzd held"}, out_ftzd, 1'b0);
        @(negedge clk);
        chk_bit({req, " rsvd one cycle"}, out_rsvd, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_vs = {S1, S1, S1, S1}; in_vt = {S2, S2, S2, S2};
        @(negedge clk);
        chk_bit("R9 idle valid", out_valid, 1'b0);
        chk_bit("R10 idle rsvd", out_rsvd, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_sgl_basic();
        t_sgl_nan();
        t_sgl_one_lane_nan();
        t_ftz();
        t_dbl();
        issue(mk(6'b011110, 4'b1010, 1'b0, 15'h0000, 6'b011100),
              {S1, S1, S1, S1}, {S1, S1, S1, S1}, 1'b0);
        expect_res("R1 match baseline", '0, 1'b0, 1'b0);
        t_rsvd("R1 R10 major", mk(6'b011111, 4'b1010, 1'b0, 15'h0, 6'b011100));
        t_rsvd("R1 R10 op", mk(6'b011110, 4'b1011, 1'b0, 15'h0, 6'b011100));
        t_rsvd("R1 R10 minor", mk(6'b011110, 4'b1010, 1'b0, 15'h0, 6'b011101));
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule